// File: doc/BRIEF.md
# Interrupt Event Register Bank

This block is the interrupt event corner of an Ethernet controller's register space. It holds a small bank of 32-bit registers, each with a fixed access class. The classes are read-only, read-write, write-one-to-clear and write-only. The bank is reached over a simple word-addressed read/write bus. The caller converts a byte address to a word index by dropping the two low bits, so each index selects one 32-bit word.

The transmit and receive engines report events through one-cycle set pulses. Those pulses latch into a sticky event register. The event register is gated by a per-bit enable register and folded into three registered, level-sensitive interrupt lines: transmit, receive and error. A line stays high until software has cleared, with a write of one, every enabled event bit that belongs to that line.

If software clears a bit in the same cycle that an engine sets it, the set wins, so no event is lost. Software can also raise events itself through a write-only set register, which is useful for bring-up and for testing interrupt handlers.

Top module: `irq_evt_regbank`

## Requirements
- R1: After reset, all event bits and enable bits are zero and all three interrupt outputs are low.
- R2: Reads return the stored value for the read-only, read-write and write-one-to-clear classes. A read of the write-only register at word index 3 returns zero. The enable register at index 1 is read-write over the low 8 bits, and its upper bits read as zero.
- R3: The event register is at word index 0. Writing a one to a bit clears it, and writing a zero leaves it unchanged. The bit layout is: bit 0 transmit-buffer, bit 1 transmit-frame, bit 2 receive-buffer, bit 3 receive-frame, bits 7:4 error events.
- R4: When a hardware set pulse and a software clear hit the same event bit in the same cycle, the bit ends up set.
- R5: tx_irq_o is high one cycle after either event bit 0 or event bit 1 is set and enabled. It falls only once neither of those bits is both set and enabled.
- R6: rx_irq_o behaves the same way over event bits 2 and 3.
- R7: err_irq_o behaves the same way over event bits 7:4, and it is lowered once all of them are cleared.
- R8: An event bit whose enable bit is zero still latches and reads back, but it does not drive its interrupt line. Enabling it later raises the line.
- R9: Word index 2 is a read-only pending register that reads as event AND enable. Writes to it change nothing.
- R10: Writing ones to the write-only register at word index 3 sets the matching event bits.
- R11: An index of 4 or above reads as zero, and a write to such an index changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word index (byte address / 4) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, valid while req_i and not we_i |
| tx_evt_set_i | input | 2 | Transmit event pulses: bit 0 buffer, bit 1 frame |
| rx_evt_set_i | input | 2 | Receive event pulses: bit 0 buffer, bit 1 frame |
| err_evt_set_i | input | ERR_W | Error event pulses |
| tx_irq_o | output | 1 | Transmit interrupt level |
| rx_irq_o | output | 1 | Receive interrupt level |
| err_irq_o | output | 1 | Error interrupt level |

## Verification
A wrong event bit becomes visible on the next bus read of index 0 or index 2. Because the interrupt outputs are registered, it also shows on the affected interrupt line exactly one clock after the bad state appears. A lost set, for example a clear winning a race, shows as a line that falls one cycle early and an event word with a missing bit. A line that never falls points at a wrong direction mask, and it is caught as soon as the last bit of that direction is cleared.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;

  typedef enum logic [1:0] {
    ACC_RO  = 2'd0,
    ACC_RW  = 2'd1,
    ACC_W1C = 2'd2,
    ACC_WO  = 2'd3
  } acc_e;

  localparam int NUM_REGS  = 4;
  localparam int IDX_EVT   = 0;
  localparam int IDX_ENA   = 1;
  localparam int IDX_PEND  = 2;
  localparam int IDX_SWSET = 3;

  localparam int BIT_TXB = 0;
  localparam int BIT_TXF = 1;
  localparam int BIT_RXB = 2;
  localparam int BIT_RXF = 3;
  localparam int ERR_LSB = 4;

  localparam int NUM_LINES = 3;

  function automatic acc_e acc_of(int idx);
    case (idx)
      IDX_EVT:   return ACC_W1C;
      IDX_ENA:   return ACC_RW;
      IDX_PEND:  return ACC_RO;
      default:   return ACC_WO;
    endcase
  endfunction

endpackage

// File: rtl/ierb_event_reg.sv
module ierb_event_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] evt_o
);

  // set after clear: a coincident event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_o <= '0;
    else         evt_o <= (evt_o & ~clr_i) | set_i;
  end

  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((evt_o & $past(set_i)) == $past(set_i)));

  a_r3_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((evt_o & $past(clr_i & ~set_i)) == '0));

  a_r3_zero_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ((evt_o & ~$past(clr_i | set_i)) == ($past(evt_o) & ~$past(clr_i | set_i))));

endmodule

// File: rtl/ierb_irq_line.sv
module ierb_irq_line #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] en_i,
  output logic         irq_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(src_i & en_i);
  end

  // covers R5, R6, R7 and R8 per instance
  a_r5_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(src_i & en_i)) |=> irq_o);

  a_r5_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(src_i & en_i)) |=> !irq_o);

endmodule

// File: rtl/ierb_read_mux.sv
module ierb_read_mux
  import irq_evt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rd_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [NUM_REGS-1:0][31:0] regs_i,
  output logic [31:0]               rdata_o
);

  logic [NUM_REGS-1:0][31:0] term;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_term
    if (acc_of(g) == ACC_WO) begin : g_wo
      assign term[g] = '0;
    end else begin : g_rd
      assign term[g] = (addr_i == ADDR_W'(g)) ? regs_i[g] : '0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      for (int i = 0; i < NUM_REGS; i++) rdata_o = rdata_o | term[i];
    end
  end

  a_r2_wo_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_W'(IDX_SWSET)) |-> (rdata_o == '0));

  a_r11_oor_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i >= ADDR_W'(NUM_REGS)) |-> (rdata_o == '0));

endmodule

// File: rtl/irq_evt_regbank.sv
module irq_evt_regbank
  import irq_evt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int ERR_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [1:0]        tx_evt_set_i,
  input  logic [1:0]        rx_evt_set_i,
  input  logic [ERR_W-1:0]  err_evt_set_i,
  output logic              tx_irq_o,
  output logic              rx_irq_o,
  output logic              err_irq_o
);

  localparam int EVT_W = ERR_LSB + ERR_W;

  function automatic logic [EVT_W-1:0] line_mask(int line);
    logic [EVT_W-1:0] m;
    m = '0;
    case (line)
      0:       begin m[BIT_TXB] = 1'b1; m[BIT_TXF] = 1'b1; end
      1:       begin m[BIT_RXB] = 1'b1; m[BIT_RXF] = 1'b1; end
      default: for (int b = ERR_LSB; b < EVT_W; b++) m[b] = 1'b1;
    endcase
    return m;
  endfunction

  logic                      wr_en, rd_en;
  logic [EVT_W-1:0]          evt_q, ena_q, hw_set, sw_set, sw_clr;
  logic [NUM_REGS-1:0][31:0] regs_val;
  logic [NUM_LINES-1:0]      irq_vec;
  logic                      unused_wdata;

  assign wr_en = req_i & we_i;
  assign rd_en = req_i & ~we_i;
  assign unused_wdata = ^wdata_i[31:EVT_W];

  assign hw_set = {err_evt_set_i, rx_evt_set_i, tx_evt_set_i};
  assign sw_clr = (wr_en && addr_i == ADDR_W'(IDX_EVT))   ? wdata_i[EVT_W-1:0] : '0;
  assign sw_set = (wr_en && addr_i == ADDR_W'(IDX_SWSET)) ? wdata_i[EVT_W-1:0] : '0;

  ierb_event_reg #(.W(EVT_W)) u_evt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (sw_clr),
    .set_i (hw_set | sw_set),
    .evt_o (evt_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    ena_q <= '0;
    else if (wr_en && addr_i == ADDR_W'(IDX_ENA))   ena_q <= wdata_i[EVT_W-1:0];
  end

  always_comb begin
    regs_val            = '0;
    regs_val[IDX_EVT]   = 32'(evt_q);
    regs_val[IDX_ENA]   = 32'(ena_q);
    regs_val[IDX_PEND]  = 32'(evt_q & ena_q);
  end

  ierb_read_mux #(.ADDR_W(ADDR_W)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_en_i(rd_en),
    .addr_i (addr_i),
    .regs_i (regs_val),
    .rdata_o(rdata_o)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    ierb_irq_line #(.W(EVT_W)) u_line (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .src_i (evt_q & line_mask(g)),
      .en_i  (ena_q),
      .irq_o (irq_vec[g])
    );
  end

  assign tx_irq_o  = irq_vec[0];
  assign rx_irq_o  = irq_vec[1];
  assign err_irq_o = irq_vec[2];

  a_r11_oor_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && addr_i >= ADDR_W'(NUM_REGS) && hw_set == '0) |=> $stable(evt_q) && $stable(ena_q));

  a_r9_ro_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && addr_i == ADDR_W'(IDX_PEND)) |=> $stable(ena_q));

endmodule

// File: tb/tb_irq_evt_regbank.sv
module tb_irq_evt_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int ERR_W  = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [1:0]        tx_set = '0, rx_set = '0;
  logic [ERR_W-1:0]  err_set = '0;
  logic              tx_irq, rx_irq, err_irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_evt_regbank #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_evt_set_i(tx_set),
    .rx_evt_set_i(rx_set), .err_evt_set_i(err_set),
    .tx_irq_o(tx_irq), .rx_irq_o(rx_irq), .err_irq_o(err_irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = ADDR_W'(a);
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic pulse(input logic [1:0] t, input logic [1:0] r, input logic [ERR_W-1:0] e);
    @(negedge clk);
    tx_set = t; rx_set = r; err_set = e;
    @(negedge clk);
    tx_set = '0; rx_set = '0; err_set = '0;
  endtask

  // irq registers one edge after the event register; wait one more cycle
  task automatic chk_irq(input logic [2:0] exp, input string tag);
    @(negedge clk);
    chk({29'd0, err_irq, rx_irq, tx_irq}, {29'd0, exp}, tag);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk({29'd0, err_irq, rx_irq, tx_irq}, 32'd0, "R1 irqs low");
    rd(0, d); chk(d, 32'd0, "R1 events zero");
    rd(1, d); chk(d, 32'd0, "R1 enable zero");
  endtask

  task automatic t_access();
    logic [31:0] d;
    wr(1, 32'hFFFF_FFFF);
    rd(1, d); chk(d, 32'h0000_00FF, "R2 rw readback");
    wr(3, 32'h0000_0000);
    rd(3, d); chk(d, 32'd0, "R2 wo reads zero");
    wr(2, 32'h0000_00FF);
    rd(2, d); chk(d, 32'd0, "R9 ro write ignored");
    rd(1, d); chk(d, 32'h0000_00FF, "R9 enable untouched");
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(3, 32'h0000_00A5);
    rd(0, d); chk(d, 32'h0000_00A5, "R10 swset sets events");
    rd(2, d); chk(d, 32'h0000_00A5, "R9 pending equals evt and ena");
    wr(0, 32'h0000_0000);
    rd(0, d); chk(d, 32'h0000_00A5, "R3 zero write keeps");
    wr(0, 32'h0000_0021);
    rd(0, d); chk(d, 32'h0000_0084, "R3 one clears only those bits");
    wr(0, 32'h0000_00FF);
    rd(0, d); chk(d, 32'd0, "R3 clear all");
    chk_irq(3'b000, "R7 lines low after clear all");
  endtask

  task automatic t_tx();
    pulse(2'b01, 2'b00, '0);
    chk_irq(3'b001, "R5 tx rises on buffer event");
    pulse(2'b10, 2'b00, '0);
    wr(0, 32'h1);
    chk_irq(3'b001, "R5 tx held by frame event");
    wr(0, 32'h2);
    chk_irq(3'b000, "R5 tx falls after both cleared");
  endtask

  task automatic t_rx();
    pulse(2'b00, 2'b11, '0);
    chk_irq(3'b010, "R6 rx rises");
    wr(0, 32'h8);
    chk_irq(3'b010, "R6 rx held by buffer event");
    wr(0, 32'h4);
    chk_irq(3'b000, "R6 rx falls");
  endtask

  task automatic t_err();
    pulse(2'b00, 2'b00, 4'b1001);
    chk_irq(3'b100, "R7 err rises");
    wr(0, 32'h10);
    chk_irq(3'b100, "R7 err held by bit 7");
    wr(0, 32'h80);
    chk_irq(3'b000, "R7 err lowered");
  endtask

  task automatic t_race();
    logic [31:0] d;
    pulse(2'b01, 2'b00, '0);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = '0; wdata = 32'h1; tx_set = 2'b01;
    @(negedge clk);
    req = 1'b0; we = 1'b0; tx_set = '0;
    rd(0, d); chk(d, 32'h1, "R4 set wins over clear");
    chk({31'd0, tx_irq}, 32'd1, "R4 tx still high");
    wr(0, 32'h1);
    chk_irq(3'b000, "R4 later clear drops tx");
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(1, 32'h0000_00F7);
    pulse(2'b00, 2'b10, '0);
    chk_irq(3'b000, "R8 masked bit no irq");
    rd(0, d); chk(d, 32'h8, "R8 masked bit latched");
    wr(1, 32'h0000_00FF);
    chk_irq(3'b010, "R8 enable raises rx");
    wr(0, 32'h8);
    chk_irq(3'b000, "R8 cleared");
  endtask

  task automatic t_oor();
    logic [31:0] d;
    wr(4, 32'h0000_00AA);
    wr(63, 32'h0000_0000);
    rd(4, d); chk(d, 32'd0, "R11 oor reads zero");
    rd(1, d); chk(d, 32'h0000_00FF, "R11 enable unchanged");
    rd(0, d); chk(d, 32'd0, "R11 events unchanged");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_access();
    t_w1c();
    t_tx();
    t_rx();
    t_err();
    t_race();
    t_mask();
    t_oor();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule